// File: doc/BRIEF.md
# Armed Monitor Capture Controller

This block produces a single-clock strobe that tells the monitor history registers elsewhere in the chip to freeze their contents. Software can fire the strobe at once with a register command. It can also arm the block, which then waits for the sequencer's next decision-cycle check in which the event being processed carries the capture qualifier. The qualifier is a per-event bit that was stored alongside the event, so it is stable during the check. An armed capture fires once and then disarms.

A sticky done flag is set with every strobe and stays set until software arms the block again or initializes it, so software can poll it to learn when the frozen monitor data is ready to read. Every interface here is a plain control or status pin with no stream handshake. A command is a single-cycle write strobe with a 2-bit code that is always accepted, so there is no back-pressure.

Top module: `mcap_ctrl`

## Requirements
- R1: After reset, `cap_pulse` and `cap_done` are 0 and the block is not armed.
- R2: A write with code 1 (fire) makes `cap_pulse` high for exactly the one clock after the write edge, and sets `cap_done` in that same clock.
- R3: A write with code 2 (arm) arms the block. The next clock in which `chk_strobe` and `evt_qual` are both high then makes `cap_pulse` high in the following clock and sets `cap_done`.
- R4: While armed, a check with `evt_qual` low, or `evt_qual` high with no check, gives no pulse, and the arm is kept.
- R5: An armed capture clears the arm, so later qualified checks give no pulse until the block is armed again.
- R6: When the block is not armed, a qualified check gives no pulse.
- R7: `cap_done` stays set after a capture. An arm write clears it, and it reads 0 from the clock after that write.
- R8: A fire write in the same clock as an armed qualified check gives a single one-clock pulse and uses up the arm.
- R9: A write with code 3 (initialize) clears both the arm and `cap_done` and suppresses any pulse from a qualified check in that clock.
- R10: A write with code 0 (no-op) changes neither the arm, the pulse nor the flag.
- R11: An arm write in the same clock as an armed qualified check gives the pulse, leaves `cap_done` at 1 and leaves the block armed for the next qualified check.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_wr | input | 1 | Control register write strobe |
| cmd_code | input | 2 | Command: 0 no-op, 1 fire, 2 arm, 3 initialize |
| chk_strobe | input | 1 | One-clock check pulse from the decision-cycle sequencer |
| evt_qual | input | 1 | Buffered capture qualifier of the current event |
| cap_pulse | output | 1 | One-clock capture-monitor-data strobe |
| cap_done | output | 1 | Sticky flag: a capture has occurred since the last arm |

## Verification
Every result is registered once. The pulse, the flag and the arm state are all due in the clock after the edge that samples the command or the check, so the latency is one cycle for each. The bench drives inputs on the falling edge and lets one rising edge pass. It then compares both outputs at the next falling edge against a reference model that applies the requirement rules to the same inputs. The arm state, which is internal, is observed through the pulse on a later qualified check.

// File: rtl/mcap_pkg.sv
package mcap_pkg;
  localparam int CMD_W = 2;

  typedef enum logic [CMD_W-1:0] {
    CMD_NOP  = 2'd0,
    CMD_FIRE = 2'd1,
    CMD_ARM  = 2'd2,
    CMD_INIT = 2'd3
  } mcap_cmd_e;
endpackage

// File: rtl/mcap_cmd_dec.sv
module mcap_cmd_dec
  import mcap_pkg::*;
(
  input  logic             wr,
  input  logic [CMD_W-1:0] code,
  output logic             do_fire,
  output logic             do_arm,
  output logic             do_init
);
  always_comb begin
    do_fire = 1'b0;
    do_arm  = 1'b0;
    do_init = 1'b0;
    if (wr) begin
      unique case (mcap_cmd_e'(code))
        CMD_FIRE: do_fire = 1'b1;
        CMD_ARM:  do_arm  = 1'b1;
        CMD_INIT: do_init = 1'b1;
        default:  ;
      endcase
    end
  end
endmodule

// File: rtl/mcap_arm_ctrl.sv
module mcap_arm_ctrl (
  input  logic clk,
  input  logic rst_n,
  input  logic do_arm,
  input  logic do_init,
  input  logic chk,
  input  logic qual,
  output logic armed,
  output logic arm_hit
);
  // A qualified check consumes an arm that was in place before this edge.
  assign arm_hit = armed && chk && qual && !do_init;

  always_ff @(posedge clk) begin
    if (!rst_n)       armed <= 1'b0;
    else if (do_init) armed <= 1'b0;
    else if (do_arm)  armed <= 1'b1;
    else if (arm_hit) armed <= 1'b0;
  end

  p_arm_consumed_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && chk && qual && !do_arm && !do_init) |=> !armed);
  p_arm_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && !(chk && qual) && !do_init) |=> armed);
  p_init_disarms_r9: assert property (@(posedge clk) disable iff (!rst_n)
    do_init |=> !armed);
endmodule

// File: rtl/mcap_out.sv
module mcap_out (
  input  logic clk,
  input  logic rst_n,
  input  logic do_fire,
  input  logic do_arm,
  input  logic do_init,
  input  logic arm_hit,
  output logic pulse,
  output logic done
);
  logic fire_any;
  assign fire_any = (do_fire || arm_hit) && !do_init;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pulse <= 1'b0;
      done  <= 1'b0;
    end else begin
      pulse <= fire_any;
      if (do_init)       done <= 1'b0;
      else if (fire_any) done <= 1'b1;
      else if (do_arm)   done <= 1'b0;
    end
  end

  p_done_with_pulse_r7: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> done);
  p_done_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (done && !do_arm && !do_init) |=> done);
  p_init_clears_done_r9: assert property (@(posedge clk) disable iff (!rst_n)
    do_init |=> (!done && !pulse));
endmodule

// File: rtl/mcap_ctrl.sv
module mcap_ctrl
  import mcap_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_wr,
  input  logic [CMD_W-1:0] cmd_code,
  input  logic             chk_strobe,
  input  logic             evt_qual,
  output logic             cap_pulse,
  output logic             cap_done
);
  logic do_fire, do_arm, do_init;
  logic armed, arm_hit;

  mcap_cmd_dec u_dec (
    .wr(cmd_wr), .code(cmd_code),
    .do_fire(do_fire), .do_arm(do_arm), .do_init(do_init)
  );

  mcap_arm_ctrl u_arm (
    .clk(clk), .rst_n(rst_n), .do_arm(do_arm), .do_init(do_init),
    .chk(chk_strobe), .qual(evt_qual), .armed(armed), .arm_hit(arm_hit)
  );

  mcap_out u_out (
    .clk(clk), .rst_n(rst_n), .do_fire(do_fire), .do_arm(do_arm),
    .do_init(do_init), .arm_hit(arm_hit), .pulse(cap_pulse), .done(cap_done)
  );

  p_fire_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code == CMD_FIRE) |=> (cap_pulse && cap_done));
  p_armed_hit_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && chk_strobe && evt_qual && !(cmd_wr && cmd_code == CMD_INIT))
      |=> cap_pulse);
  p_unarmed_quiet_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!armed && !(cmd_wr && cmd_code == CMD_FIRE)) |=> !cap_pulse);
  p_arm_clears_done_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_wr && cmd_code == CMD_ARM && !(armed && chk_strobe && evt_qual))
      |=> !cap_done);
endmodule

// File: tb/mcap_ctrl_test.sv
module mcap_ctrl_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cmd_wr = 1'b0;
  logic [1:0] cmd_code = 2'd0;
  logic       chk_strobe = 1'b0;
  logic       evt_qual = 1'b0;
  logic       cap_pulse, cap_done;

  int n_checks = 0;
  int n_fails  = 0;
  bit m_armed = 1'b0;
  bit m_pulse = 1'b0;
  bit m_done  = 1'b0;

  always #5 clk = ~clk;

  mcap_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cmd_wr(cmd_wr), .cmd_code(cmd_code),
    .chk_strobe(chk_strobe), .evt_qual(evt_qual),
    .cap_pulse(cap_pulse), .cap_done(cap_done)
  );

  // Reference rules: returns {armed, pulse, done} after one edge.
  function automatic logic [2:0] model(bit a, bit d, bit wr, logic [1:0] c,
                                       bit ck, bit q);
    bit fire, arm, init, hit, p, na, nd;
    fire = wr && c == 2'd1;
    arm  = wr && c == 2'd2;
    init = wr && c == 2'd3;
    hit  = a && ck && q && !init;
    p    = (fire || hit) && !init;
    na   = init ? 1'b0 : (arm ? 1'b1 : (hit ? 1'b0 : a));
    nd   = init ? 1'b0 : (p ? 1'b1 : (arm ? 1'b0 : d));
    return {na, p, nd};
  endfunction

  task automatic check(string tag);
    n_checks++;
    if (cap_pulse !== m_pulse || cap_done !== m_done) begin
      n_fails++;
      $display("FAIL %s: pulse/done actual %b/%b expected %b/%b",
               tag, cap_pulse, cap_done, m_pulse, m_done);
    end
  endtask

  task automatic step(bit wr, logic [1:0] c, bit ck, bit q, string tag);
    logic [2:0] nx;
    cmd_wr = wr; cmd_code = c; chk_strobe = ck; evt_qual = q;
    nx = model(m_armed, m_done, wr, c, ck, q);
    @(posedge clk);
    {m_armed, m_pulse, m_done} = nx;
    @(negedge clk);
    cmd_wr = 1'b0; chk_strobe = 1'b0; evt_qual = 1'b0;
    check(tag);
  endtask

  initial begin
    #200000;
    n_checks++; n_fails++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    repeat (3) @(negedge clk);
    check("R1 reset");
    rst_n = 1'b1;
    step(0, 0, 1, 1, "R1 idle after reset");
    step(0, 0, 1, 1, "R6 unarmed qualified check");
    step(1, 1, 0, 0, "R2 fire pulse");
    step(0, 0, 0, 0, "R2 pulse one clock");
    step(1, 0, 0, 0, "R10 nop keeps done");
    step(1, 2, 0, 0, "R7 arm clears done");
    step(0, 0, 1, 0, "R4 check without qualifier");
    step(0, 0, 0, 1, "R4 qualifier without check");
    step(0, 0, 1, 1, "R3 armed qualified capture");
    step(0, 0, 0, 0, "R7 done sticky");
    step(0, 0, 1, 1, "R5 arm consumed");
    step(1, 2, 0, 0, "R8 arm");
    step(1, 1, 1, 1, "R8 fire with armed hit");
    step(0, 0, 0, 0, "R8 single pulse");
    step(0, 0, 1, 1, "R8 arm used up");
    step(1, 2, 0, 0, "R9 arm");
    step(1, 3, 1, 1, "R9 init suppresses");
    step(0, 0, 1, 1, "R9 arm cleared");
    step(1, 2, 0, 0, "R11 arm");
    step(1, 2, 1, 1, "R11 rearm with hit");
    step(0, 0, 1, 1, "R11 still armed");
    step(1, 2, 0, 0, "R10 arm");
    step(1, 0, 1, 0, "R10 nop while armed");
    step(0, 0, 1, 1, "R10 arm intact");
    for (int i = 0; i < 400; i++) begin
      bit wr;
      wr = ($urandom % 4) == 0;
      step(wr, 2'($urandom % 4), ($urandom % 3) == 0, $urandom % 2, "random");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule